// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches the synchronized input levels of one bank of general-purpose pins and turns the events that software asked for into pending status bits. Each pin carries its own 3-bit event kind from its configuration: falling edge, rising edge, either edge, low level or high level. When the selected condition is seen on a pin, that pin's status bit is set.

Software reaches the block through a small memory-mapped bus. It can set enable bits, clear enable bits, read back the enabled set, and read the pending status. A status read returns the pending bits and clears them in the same access, so no separate acknowledge write is needed. Events that arrive while the read is in progress are kept for the next read. Status is recorded on every pin whether or not that pin is enabled. The enable set only decides what reaches the single interrupt output of the bank, which is high while any pending bit is also enabled.

The pin inputs are assumed to be synchronized and filtered upstream. Edges are found by comparing each input with its value one clock earlier.

Top module: `gpio_evt_bank`

## Requirements
- R1: With event kind 0 on a pin, a 1-to-0 change of that pin's input sets its status bit, and a 0-to-1 change does not.
- R2: Event kind 1 sets status on a 0-to-1 change only. Event kind 2 sets status on a change in either direction.
- R3: Event kind 3 (low) and kind 4 (high) set the status bit on every clock while the level holds. A bit cleared by a read is therefore set again at once if the level is still present.
- R4: Status bits are recorded whether or not the pin is enabled. A pending bit on a disabled pin is still returned by a later status read.
- R5: A read of offset 0x2C returns the status and clears it. Read data appears on the clock edge that ends the read access and holds until the next read.
- R6: A write to offset 0x20 sets the enable bits written as 1 and leaves the bits written as 0 unchanged.
- R7: A write to offset 0x24 clears the enable bits written as 1 and leaves the bits written as 0 unchanged.
- R8: A read of offset 0x28 returns the current enable set. A read of any unmapped offset returns zero.
- R9: The interrupt output is high exactly when some pin has both its status bit and its enable bit set. It follows register changes with no added delay.
- R10: Event kinds 5, 6 and 7 are reserved. A pin set to one of them never sets its status bit, whatever its input does.
- R11: If an event and a status read fall on the same clock edge, the read returns the old status and the new event stays pending.
- R12: Reset clears the enable set, the status, the stored previous input samples and the read data. The interrupt output is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPINS | Synchronized pin input levels |
| pin_evt_sel | input | 3*NPINS | Event kind per pin; pin i uses bits [3i+2:3i] |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Registered read data |
| irq | output | 1 | Bank interrupt request |

## Verification
The hardest case to reach from the ports is an event that lands on the same clock edge as a status read. The read has to return the old status while the new bit survives. The stimulus arranges this by raising a pin whose event kind is falling edge and clearing status first. It then drives the pin low and starts the status read on the same falling clock edge. The next two reads must return zero and then the new bit. Level re-arming is reached in a similar way: a level is held across back-to-back reads, and each read must still return the bit.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  // Per-pin event kinds; values 5..7 are reserved and never fire.
  typedef enum logic [2:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } evt_kind_e;

  localparam int SEL_W = 3;

  // Register byte offsets inside the bank window.
  localparam int OFS_EN   = 'h20;
  localparam int OFS_DIS  = 'h24;
  localparam int OFS_MASK = 'h28;
  localparam int OFS_STAT = 'h2C;

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_i,
  input  logic [NPINS*SEL_W-1:0] sel_i,
  output logic [NPINS-1:0]       hit_o
);

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] prev_d;

  // Previous sample follows the input every cycle.
  always_comb begin
    prev_d = pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [SEL_W-1:0] kind;
    logic             rise;
    logic             fall;

    assign kind = sel_i[g*SEL_W +: SEL_W];
    assign rise = pin_i[g] & ~prev_q[g];
    assign fall = ~pin_i[g] & prev_q[g];

    always_comb begin
      case (kind)
        EV_FALL: hit_o[g] = fall;
        EV_RISE: hit_o[g] = rise;
        EV_BOTH: hit_o[g] = rise | fall;
        EV_LOW:  hit_o[g] = ~pin_i[g];
        EV_HIGH: hit_o[g] = pin_i[g];
        default: hit_o[g] = 1'b0;
      endcase
    end

    a_r10_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (kind > 3'd4) |-> !hit_o[g]);

    a_r3_high_level_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 3'd4 && pin_i[g]) |-> hit_o[g]);

    a_r1_fall_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 3'd0 && hit_o[g]) |=> ($past(pin_i[g]) == 1'b0 && prev_q[g] == 1'b0));
  end

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  hit_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  rdata_o,
  output logic [NPINS-1:0]  status_o,
  output logic [NPINS-1:0]  mask_o
);

  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic             wr_en, wr_dis, rd_any, rd_stat;
  logic [NPINS-1:0] mask_q, mask_d;
  logic [NPINS-1:0] status_q, status_d;
  logic [NPINS-1:0] rdata_q, rdata_d;

  // Access decode
  always_comb begin
    wr_en   = bus_sel &  bus_wr & (bus_addr == A_EN);
    wr_dis  = bus_sel &  bus_wr & (bus_addr == A_DIS);
    rd_any  = bus_sel & ~bus_wr;
    rd_stat = rd_any & (bus_addr == A_STAT);
  end

  // Next state
  always_comb begin
    mask_d = mask_q;
    if (wr_en)  mask_d = mask_d | bus_wdata;
    if (wr_dis) mask_d = mask_d & ~bus_wdata;

    status_d = (rd_stat ? '0 : status_q) | hit_i;

    case (bus_addr)
      A_MASK:  rdata_d = mask_q;
      A_STAT:  rdata_d = status_q;
      default: rdata_d = '0;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      status_q <= '0;
      rdata_q  <= '0;
    end else begin
      mask_q   <= mask_d;
      status_q <= status_d;
      if (rd_any) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign status_o = status_q;
  assign mask_o   = mask_q;

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (status_q == $past(hit_i)));

  a_r4_event_records: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((status_q & $past(hit_i)) == $past(hit_i)));

  a_r6_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((mask_q & $past(bus_wdata)) == '0));

  a_r5_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(rdata_q));

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_lvl,
  input  logic [NPINS*SEL_W-1:0] pin_evt_sel,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [NPINS-1:0]       bus_wdata,
  output logic [NPINS-1:0]       bus_rdata,
  output logic                   irq
);

  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] status;
  logic [NPINS-1:0] mask;

  gpio_evt_detect #(.NPINS(NPINS)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_lvl),
    .sel_i (pin_evt_sel),
    .hit_o (hit)
  );

  gpio_evt_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rdata_o   (bus_rdata),
    .status_o  (status),
    .mask_o    (mask)
  );

  assign irq = |(status & mask);

  a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0 && mask != '0));

endmodule

// File: tb/gpio_evt_bank_tb.sv
`timescale 1ns/1ps
module gpio_evt_bank_tb;

  localparam int NP = 32;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP-1:0]   pin_lvl;
  logic [NP*3-1:0] pin_evt_sel;
  logic            bus_sel, bus_wr;
  logic [AW-1:0]   bus_addr;
  logic [NP-1:0]   bus_wdata;
  logic [NP-1:0]   bus_rdata;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_evt_bank #(.NPINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_evt_sel(pin_evt_sel),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    pin_lvl[i] = v;
    @(negedge clk);
  endtask

  task automatic set_sel(input int i, input logic [2:0] v);
    @(negedge clk);
    pin_evt_sel[3*i +: 3] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [NP-1:0] d;
    chk("R12 irq after reset", {31'd0, irq}, 32'd0);
    chk("R12 rdata after reset", bus_rdata, 32'd0);
    bus_read(8'h2C, d); chk("R12 status after reset", d, 32'd0);
    bus_read(8'h28, d); chk("R12 mask after reset", d, 32'd0);
  endtask

  task automatic t_falling;
    logic [NP-1:0] d;
    set_pin(0, 1'b1);
    bus_read(8'h2C, d); chk("R1 rising ignored by kind 0", d, 32'd0);
    set_pin(0, 1'b0);
    bus_read(8'h2C, d); chk("R1 falling sets bit0", d, 32'h1);
    bus_read(8'h2C, d); chk("R5 status cleared by read", d, 32'd0);
  endtask

  task automatic t_rise_both;
    logic [NP-1:0] d;
    set_sel(1, 3'd1);
    set_pin(1, 1'b1);
    bus_read(8'h2C, d); chk("R2 rising sets bit1", d, 32'h2);
    set_pin(1, 1'b0);
    bus_read(8'h2C, d); chk("R2 falling ignored by kind 1", d, 32'd0);
    set_sel(2, 3'd2);
    set_pin(2, 1'b1);
    bus_read(8'h2C, d); chk("R2 both: rise sets bit2", d, 32'h4);
    set_pin(2, 1'b0);
    bus_read(8'h2C, d); chk("R2 both: fall sets bit2", d, 32'h4);
  endtask

  task automatic t_reserved;
    logic [NP-1:0] d;
    set_sel(3, 3'd5); set_sel(6, 3'd7); set_sel(8, 3'd6);
    set_pin(3, 1'b1); set_pin(6, 1'b1); set_pin(8, 1'b1);
    set_pin(3, 1'b0); set_pin(6, 1'b0); set_pin(8, 1'b0);
    bus_read(8'h2C, d); chk("R10 reserved kinds never set", d, 32'd0);
  endtask

  task automatic t_level;
    logic [NP-1:0] d;
    set_sel(4, 3'd4);
    set_pin(4, 1'b1);
    repeat (3) @(negedge clk);
    bus_read(8'h2C, d); chk("R3 high level sets bit4", d, 32'h10);
    bus_read(8'h2C, d); chk("R3 held level re-sets after read", d, 32'h10);
    set_pin(4, 1'b0);
    bus_read(8'h2C, d); chk("R3 last pending returned", d, 32'h10);
    bus_read(8'h2C, d); chk("R3 level gone, status stays clear", d, 32'd0);
    set_pin(7, 1'b1);
    set_sel(7, 3'd3);
    set_pin(7, 1'b0);
    bus_read(8'h2C, d); chk("R3 low level sets bit7", d, 32'h80);
    set_pin(7, 1'b1);
    bus_read(8'h2C, d); chk("R3 low level re-set during read", d, 32'h80);
    bus_read(8'h2C, d); chk("R3 low level released", d, 32'd0);
  endtask

  task automatic t_mask;
    logic [NP-1:0] d;
    bus_write(8'h20, 32'h0000_00F0);
    bus_read(8'h28, d); chk("R6 enable sets bits", d, 32'hF0);
    bus_write(8'h20, 32'h0000_0001);
    bus_read(8'h28, d); chk("R6 zeros leave bits", d, 32'hF1);
    bus_write(8'h24, 32'h0000_0030);
    bus_read(8'h28, d); chk("R7 disable clears only ones", d, 32'hC1);
    bus_read(8'h00, d); chk("R8 unmapped offset reads zero", d, 32'd0);
  endtask

  task automatic t_irq;
    logic [NP-1:0] d;
    set_pin(1, 1'b1);
    chk("R4 disabled pin: irq low", {31'd0, irq}, 32'd0);
    bus_write(8'h20, 32'h2);
    chk("R9 enable pending pin raises irq", {31'd0, irq}, 32'd1);
    bus_write(8'h24, 32'h2);
    chk("R9 disable drops irq", {31'd0, irq}, 32'd0);
    bus_read(8'h2C, d); chk("R4 status kept while disabled", d, 32'h2);
    bus_write(8'h20, 32'h2);
    chk("R9 cleared status: irq low", {31'd0, irq}, 32'd0);
    set_pin(1, 1'b0);
    set_pin(1, 1'b1);
    chk("R9 new event on enabled pin raises irq", {31'd0, irq}, 32'd1);
    bus_read(8'h2C, d);
    chk("R9 irq falls after status read", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_collide;
    logic [NP-1:0] d;
    set_pin(0, 1'b1);
    bus_read(8'h2C, d);
    @(negedge clk);
    pin_lvl[0] = 1'b0;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h2C;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R11 colliding read returns old status", bus_rdata, 32'd0);
    chk("R11 new event raises irq", {31'd0, irq}, 32'd1);
    bus_read(8'h2C, d); chk("R11 event kept for next read", d, 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pin_lvl = '0; pin_evt_sel = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_falling;
    t_rise_both;
    t_reserved;
    t_level;
    t_mask;
    t_irq;
    t_collide;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule